// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the address and count state for a set of DMA channels. Each channel has a 16-bit base address and a 16-bit base count. It also has a working address and a counter of units already moved. Software reaches all of these through one 8-bit port. A single byte-pointer bit, shared by every channel, decides whether an access touches the low or the high byte. The pointer flips after every read or write. A separate strobe from the controller's command logic brings the pointer back to the low byte.

A write of the high byte loads the working registers again. The working address takes the base address, and the moved-unit counter returns to zero. A low-byte write changes only the stored base. Reads show progress rather than the stored values. The count register reads back as the scaled base count minus the units moved. The address register reads back as the working address plus the units moved, or minus them when that channel is in decrement mode. The transfer engine advances a channel's counter with a one-cycle strobe.

A `SHIFT` parameter serves a word-wide controller instance. The port offset is taken from address bits above the lowest `SHIFT` bits. Working values carry `SHIFT` extra low bits, and every byte read is taken `SHIFT` bits higher.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, the byte pointer selects the low byte, and every base, working address and moved-unit counter is zero. Both bytes of every register therefore read as 0x00.
- R2: The port offset is `addr_i[SHIFT+2:SHIFT]`. Offset bit 0 selects the address register (0) or the count register (1), and offset bits 2:1 give the channel number.
- R3: The byte pointer is shared by all channels and flips on every read or write. Pointer value 0 means the low byte and 1 means the high byte. Read and write are never requested in the same cycle.
- R4: A write while the pointer is 0 replaces bits 7:0 of the selected base. It leaves the working address and the moved-unit counter untouched.
- R5: A write while the pointer is 1 replaces bits 15:8 of the selected base. It then sets that channel's working address to the base address shifted left by `SHIFT` and clears its moved-unit counter.
- R6: The count register reads as (base count << `SHIFT`) minus the moved-unit counter, modulo 2^(16+`SHIFT`).
- R7: The address register reads as the working address plus the moved-unit counter. When `dec_mode_i` is set for that channel it reads as the working address minus the counter instead, modulo 2^(16+`SHIFT`).
- R8: A read returns bits [`SHIFT`+8*pointer +: 8] of the selected value. The byte appears on `rdata_o` in the cycle after `rd_i`, and `rdata_o` holds its value until the next read.
- R9: `ptr_clr_i` sets the pointer to 0. It takes priority over a toggle from an access in the same cycle, and that access still uses the old pointer value.
- R10: A pulse on `xfer_inc_i[c]` increments channel c's moved-unit counter by one. A high-byte write to channel c in the same cycle takes priority and leaves the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3+SHIFT | Port address; offset in bits SHIFT+2:SHIFT |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid the cycle after rd_i |
| ptr_clr_i | input | 1 | Return byte pointer to low byte |
| dec_mode_i | input | NCH | Per-channel decrement mode from the mode register |
| xfer_inc_i | input | NCH | Per-channel one-unit transfer progress pulse |

## Verification
The assertions assume that `wr_i` and `rd_i` are never high in the same cycle, and one of them checks this. They also assume that `dec_mode_i` changes only between transfers. The stimulus drives every access as a single-cycle strobe set up on the falling edge. It never combines a read with a write. It changes `dec_mode_i` only in a cycle that has no access and no progress pulse. Accesses come in low/high pairs, so the pointer is known at every step. The two cases where strobes coincide are driven on purpose: a pointer clear together with a write, and a progress pulse together with a high-byte write.

// File: rtl/dma_ar_pkg.sv
package dma_ar_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BASE_W = 2 * BYTE_W;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dma_ar_decode.sv
module dma_ar_decode #(
  parameter int unsigned SHIFT = 0,
  parameter int unsigned NCH   = 4,
  localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned OFF_W = CH_W + 1,
  localparam int unsigned AW    = OFF_W + SHIFT
) (
  input  logic [AW-1:0]       addr_i,
  output logic [CH_W-1:0]     ch_o,
  output dma_ar_pkg::reg_sel_e sel_o
);
  logic [OFF_W-1:0] off;

  assign off   = addr_i[SHIFT +: OFF_W];
  assign ch_o  = off[OFF_W-1:1];
  assign sel_o = dma_ar_pkg::reg_sel_e'(off[0]);
endmodule

// File: rtl/dma_ar_byte_ptr.sv
module dma_ar_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic access_i,
  input  logic clr_i,
  output logic hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_o <= 1'b0;
    else if (clr_i)    hi_o <= 1'b0;
    else if (access_i) hi_o <= ~hi_o;
  end

  // R9
  ptr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !hi_o);

  // R3
  ptr_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && !clr_i) |=> (hi_o != $past(hi_o)));
endmodule

// File: rtl/dma_ar_chan.sv
module dma_ar_chan #(
  parameter int unsigned SHIFT = 0,
  localparam int unsigned BW    = dma_ar_pkg::BASE_W,
  localparam int unsigned VAL_W = BW + SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_addr_i,
  input  logic             wr_cnt_i,
  input  logic             hi_i,
  input  logic [7:0]       wdata_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [VAL_W-1:0] addr_val_o,
  output logic [VAL_W-1:0] cnt_val_o
);
  logic [BW-1:0]    base_addr_q, base_cnt_q;
  logic [VAL_W-1:0] cur_addr_q, xfer_q;
  logic [BW-1:0]    base_addr_d;
  logic             reinit;

  assign reinit = (wr_addr_i || wr_cnt_i) && hi_i;

  always_comb begin
    base_addr_d = base_addr_q;
    if (wr_addr_i) begin
      if (hi_i) base_addr_d[15:8] = wdata_i;
      else      base_addr_d[7:0]  = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
    end else begin
      base_addr_q <= base_addr_d;
      if (wr_cnt_i) begin
        if (hi_i) base_cnt_q[15:8] <= wdata_i;
        else      base_cnt_q[7:0]  <= wdata_i;
      end
    end
  end

  // reload wins over a coincident progress pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_addr_q <= '0;
      xfer_q     <= '0;
    end else if (reinit) begin
      cur_addr_q <= VAL_W'(base_addr_d) << SHIFT;
      xfer_q     <= '0;
    end else if (inc_i) begin
      xfer_q     <= xfer_q + VAL_W'(1);
    end
  end

  assign addr_val_o = dec_i ? (cur_addr_q - xfer_q) : (cur_addr_q + xfer_q);
  assign cnt_val_o  = (VAL_W'(base_cnt_q) << SHIFT) - xfer_q;

  // R5
  reload_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_addr_i && hi_i) |=> (addr_val_o == (VAL_W'(base_addr_q) << SHIFT)));

  // R5
  reload_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt_i && hi_i) |=> (cnt_val_o == (VAL_W'(base_cnt_q) << SHIFT)));

  // R4
  low_no_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_addr_i || wr_cnt_i) && !hi_i && !inc_i) |=> ($stable(addr_val_o) || $changed(dec_i)));

  // R10
  progress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_addr_i && !wr_cnt_i) |=> (cnt_val_o == $past(cnt_val_o) - VAL_W'(1)));
endmodule

// File: rtl/dma_ar_rd_mux.sv
module dma_ar_rd_mux #(
  parameter int unsigned SHIFT = 0,
  parameter int unsigned NCH   = 4,
  localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned VAL_W = dma_ar_pkg::BASE_W + SHIFT
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_i,
  input  logic [CH_W-1:0]       ch_i,
  input  dma_ar_pkg::reg_sel_e  sel_i,
  input  logic                  hi_i,
  input  logic [VAL_W-1:0]      addr_vals_i [NCH],
  input  logic [VAL_W-1:0]      cnt_vals_i  [NCH],
  output logic [7:0]            rdata_o
);
  logic [VAL_W-1:0] val;
  logic [7:0]       byte_sel;

  always_comb begin
    val = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_i == CH_W'(c))
        val = (sel_i == dma_ar_pkg::SEL_CNT) ? cnt_vals_i[c] : addr_vals_i[c];
    end
  end

  assign byte_sel = hi_i ? val[SHIFT+8 +: 8] : val[SHIFT +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= byte_sel;
  end

  // R8
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int unsigned SHIFT = 0,
  parameter int unsigned NCH   = 4,
  localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned AW    = CH_W + 1 + SHIFT,
  localparam int unsigned VAL_W = dma_ar_pkg::BASE_W + SHIFT
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [7:0]     wdata_i,
  output logic [7:0]     rdata_o,
  input  logic           ptr_clr_i,
  input  logic [NCH-1:0] dec_mode_i,
  input  logic [NCH-1:0] xfer_inc_i
);
  logic [CH_W-1:0]      ch;
  dma_ar_pkg::reg_sel_e sel;
  logic                 hi;
  logic [VAL_W-1:0]     addr_vals [NCH];
  logic [VAL_W-1:0]     cnt_vals  [NCH];

  dma_ar_decode #(.SHIFT(SHIFT), .NCH(NCH)) i_decode (
    .addr_i (addr_i),
    .ch_o   (ch),
    .sel_o  (sel)
  );

  dma_ar_byte_ptr i_byte_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .access_i (wr_i | rd_i),
    .clr_i    (ptr_clr_i),
    .hi_o     (hi)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic hit;
    assign hit = wr_i && (ch == CH_W'(c));

    dma_ar_chan #(.SHIFT(SHIFT)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_addr_i  (hit && (sel == dma_ar_pkg::SEL_ADDR)),
      .wr_cnt_i   (hit && (sel == dma_ar_pkg::SEL_CNT)),
      .hi_i       (hi),
      .wdata_i    (wdata_i),
      .inc_i      (xfer_inc_i[c]),
      .dec_i      (dec_mode_i[c]),
      .addr_val_o (addr_vals[c]),
      .cnt_val_o  (cnt_vals[c])
    );
  end

  dma_ar_rd_mux #(.SHIFT(SHIFT), .NCH(NCH)) i_rd_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .ch_i        (ch),
    .sel_i       (sel),
    .hi_i        (hi),
    .addr_vals_i (addr_vals),
    .cnt_vals_i  (cnt_vals),
    .rdata_o     (rdata_o)
  );

  // R3
  one_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && rd_i));
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  // op: 0 write, 1 read+check, 2 pointer clear, 3 progress pulse (off = channel)
  typedef struct packed {
    logic [1:0] op;
    logic [2:0] off;
    logic [7:0] data;
    logic [3:0] dir;
    logic [7:0] exp;
  } vec_t;

  localparam int NVEC = 41;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 3'd0, 8'h34, 4'h0, 8'h00}, // R2 ch0 address low
    '{2'd0, 3'd0, 8'h12, 4'h0, 8'h00}, // R5 high reloads
    '{2'd1, 3'd0, 8'h00, 4'h0, 8'h34}, // R8 low byte
    '{2'd1, 3'd0, 8'h00, 4'h0, 8'h12}, // R8 high byte
    '{2'd0, 3'd1, 8'h10, 4'h0, 8'h00},
    '{2'd0, 3'd1, 8'h00, 4'h0, 8'h00},
    '{2'd3, 3'd0, 8'h00, 4'h0, 8'h00}, // R10
    '{2'd3, 3'd0, 8'h00, 4'h0, 8'h00},
    '{2'd3, 3'd0, 8'h00, 4'h0, 8'h00},
    '{2'd1, 3'd1, 8'h00, 4'h0, 8'h0D}, // R6 0x10-3
    '{2'd1, 3'd1, 8'h00, 4'h0, 8'h00},
    '{2'd1, 3'd0, 8'h00, 4'h0, 8'h37}, // R7 0x1234+3
    '{2'd1, 3'd0, 8'h00, 4'h0, 8'h12},
    '{2'd1, 3'd0, 8'h00, 4'h1, 8'h31}, // R7 decrement 0x1234-3
    '{2'd1, 3'd0, 8'h00, 4'h1, 8'h12},
    '{2'd0, 3'd2, 8'h00, 4'h0, 8'h00}, // R2 ch1 address
    '{2'd0, 3'd2, 8'h01, 4'h0, 8'h00},
    '{2'd3, 3'd1, 8'h00, 4'h0, 8'h00},
    '{2'd1, 3'd2, 8'h00, 4'h2, 8'hFF}, // R7 borrow 0x0100-1
    '{2'd1, 3'd2, 8'h00, 4'h2, 8'h00},
    '{2'd1, 3'd3, 8'h00, 4'h0, 8'hFF}, // R6 wrap 0-1
    '{2'd1, 3'd3, 8'h00, 4'h0, 8'hFF},
    '{2'd0, 3'd4, 8'hFF, 4'h0, 8'h00},
    '{2'd0, 3'd4, 8'h00, 4'h0, 8'h00},
    '{2'd3, 3'd2, 8'h00, 4'h0, 8'h00},
    '{2'd1, 3'd4, 8'h00, 4'h0, 8'h00}, // R7 carry 0x00FF+1
    '{2'd1, 3'd4, 8'h00, 4'h0, 8'h01},
    '{2'd0, 3'd6, 8'hAB, 4'h0, 8'h00}, // R3 pointer shared across regs
    '{2'd0, 3'd7, 8'hCD, 4'h0, 8'h00},
    '{2'd1, 3'd6, 8'h00, 4'h0, 8'hAB},
    '{2'd1, 3'd6, 8'h00, 4'h0, 8'h00},
    '{2'd1, 3'd7, 8'h00, 4'h0, 8'h00},
    '{2'd1, 3'd7, 8'h00, 4'h0, 8'hCD}, // R3 count high 0xCD
    '{2'd0, 3'd4, 8'h55, 4'h0, 8'h00}, // R4 low write only
    '{2'd2, 3'd0, 8'h00, 4'h0, 8'h00}, // R9
    '{2'd1, 3'd4, 8'h00, 4'h0, 8'h00}, // R4 working address unchanged
    '{2'd1, 3'd4, 8'h00, 4'h0, 8'h01},
    '{2'd0, 3'd0, 8'h00, 4'h0, 8'h00},
    '{2'd0, 3'd0, 8'h20, 4'h0, 8'h00},
    '{2'd1, 3'd1, 8'h00, 4'h0, 8'h10}, // R5 counter cleared
    '{2'd1, 3'd1, 8'h00, 4'h0, 8'h00}
  };

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [2:0]     addr_i = '0;
  logic           wr_i = 1'b0, rd_i = 1'b0, ptr_clr_i = 1'b0;
  logic [7:0]     wdata_i = '0;
  logic [7:0]     rdata_o;
  logic [NCH-1:0] dec_mode_i = '0, xfer_inc_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_chan_regs i_dma_chan_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .ptr_clr_i, .dec_mode_i, .xfer_inc_i
  );

  task automatic cyc(input logic wr, input logic rd, input logic clr,
                     input logic [2:0] off, input logic [7:0] d,
                     input logic [NCH-1:0] inc);
    @(negedge clk_i);
    wr_i = wr; rd_i = rd; ptr_clr_i = clr; addr_i = off; wdata_i = d; xfer_inc_i = inc;
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0; ptr_clr_i = 1'b0; xfer_inc_i = '0;
  endtask

  task automatic rd_chk(input logic [2:0] off, input logic [7:0] exp, input string req);
    cyc(1'b0, 1'b1, 1'b0, off, 8'h00, '0);
    checks++;
    if (rdata_o !== exp) begin
      errors++;
      $display("FAIL %s off=%0d actual=%02h expected=%02h", req, off, rdata_o, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd_chk(3'd1, 8'h00, "R1");
    rd_chk(3'd1, 8'h00, "R1");
    rd_chk(3'd6, 8'h00, "R1");
    rd_chk(3'd6, 8'h00, "R1");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      dec_mode_i = VECS[i].dir;
      case (VECS[i].op)
        2'd0: cyc(1'b1, 1'b0, 1'b0, VECS[i].off, VECS[i].data, '0);
        2'd1: rd_chk(VECS[i].off, VECS[i].exp, "R2/R6/R7/R8 vector");
        2'd2: cyc(1'b0, 1'b0, 1'b1, 3'd0, 8'h00, '0);
        default: cyc(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, NCH'(1) << VECS[i].off[1:0]);
      endcase
    end
    @(negedge clk_i);
    dec_mode_i = '0;

    // R9 clear wins over the toggle of a coincident write
    cyc(1'b1, 1'b0, 1'b1, 3'd5, 8'h77, '0);
    cyc(1'b1, 1'b0, 1'b0, 3'd5, 8'h88, '0);
    cyc(1'b1, 1'b0, 1'b0, 3'd5, 8'h00, '0);
    rd_chk(3'd5, 8'h88, "R9");
    rd_chk(3'd5, 8'h00, "R9");

    // R10 reload beats a coincident progress pulse
    cyc(1'b1, 1'b0, 1'b0, 3'd6, 8'h10, '0);
    cyc(1'b1, 1'b0, 1'b0, 3'd6, 8'h00, 4'b1000);
    rd_chk(3'd6, 8'h10, "R10");
    rd_chk(3'd6, 8'h00, "R10");

    // R10 two pulses on ch3 count 0xCD00
    cyc(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 4'b1000);
    cyc(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, 4'b1000);
    rd_chk(3'd7, 8'hFE, "R10");
    rd_chk(3'd7, 8'hCC, "R10");

    // R1 reset mid-run with pointer at high byte
    cyc(1'b1, 1'b0, 1'b0, 3'd1, 8'h11, '0);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    rd_chk(3'd0, 8'h00, "R1");
    rd_chk(3'd0, 8'h00, "R1");
    cyc(1'b1, 1'b0, 1'b0, 3'd1, 8'h22, '0);
    cyc(1'b1, 1'b0, 1'b0, 3'd1, 8'h33, '0);
    rd_chk(3'd1, 8'h22, "R1");
    rd_chk(3'd1, 8'h33, "R1");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule